// File: doc/BRIEF.md
# Serial Flash Target Read Front End

This block is the target side of a serial flash port. Chip select, serial clock, serial input and hold come from pins that are already synchronised to the local clock, which samples them at several times the serial rate. The block finds the edges of the serial clock and shifts in an opcode byte, most significant bit first. Depending on the opcode, it then takes a 24-bit address and, optionally, a dummy byte. After that it returns bytes on the serial output for as long as the host keeps clocking. The returned bytes are array data, the status byte, or identification bytes.

The storage is a small register file that the surrounding logic (or a testbench) fills through a plain write port. The array only holds the low `MEM_AW` address bits; the address counter is `ADDR_W` bits wide. The status byte is an input: the write engine and protection logic that produce it live elsewhere, and bit 0 of it is the busy flag. The serial output is split into a data bit and an enable, so a pad cell or a bench can see when the line would float.

Top module: `spif_read_top`

## Requirements
- R1: When chip select falls, the block records the serial clock level on `mode3_o`: 0 means mode 0 (clock idles low) and 1 means mode 3 (clock idles high).
- R2: `so_oe_o` is low after reset, while chip select is high, and during the opcode, address and dummy bytes. Output bits change only on falling serial clock edges, most significant bit first. The first bit appears on the falling edge that follows the last input bit.
- R3: Opcode 03h takes three address bytes, high byte first. It then returns the array byte at that address, followed by the bytes at successive addresses. Array entry k is stored at index k modulo 2^MEM_AW.
- R4: Opcode 0Bh behaves like 03h, except that one extra byte of any value follows the address before the data.
- R5: The address counter is 18 bits wide, so the address after 3FFFFh is 00000h. Address bits 23 to 18 have no effect.
- R6: Opcode 05h returns `status_i`, sampled at the start of each byte, repeated without end. This also applies while the busy flag (`status_i[0]`) is 1.
- R7: Opcode 9Fh returns 62h, 06h, 12h, 00h and then repeats that sequence. While `status_i[0]` is 1, opcodes 9Fh and ABh return nothing.
- R8: Opcode ABh takes three bytes of any value and then returns 44h repeatedly.
- R9: Opcode B9h enters power-down when chip select rises after exactly one byte, unless `status_i[0]` is 1, in which case it has no effect. In power-down, every opcode except ABh returns nothing. ABh leaves power-down and otherwise behaves as in R8.
- R10: If hold falls while the serial clock is low and chip select is low, `so_oe_o` goes low and serial clock and serial input are ignored. When hold rises, the transfer continues from where it stopped.
- R11: A rise of chip select abandons any partial transfer, and the next selection decodes a fresh opcode.
- R12: An opcode with no defined meaning returns nothing for the rest of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data from host |
| hold_ni | input | 1 | Hold, active low |
| status_i | input | 8 | Status byte; bit 0 is the busy flag |
| init_we_i | input | 1 | Array write strobe |
| init_addr_i | input | MEM_AW | Array write index |
| init_data_i | input | 8 | Array write data |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Serial output enable |
| mode3_o | output | 1 | Detected clock mode (1 = mode 3) |

## Verification
The assertions assume that the serial pins are already synchronous to `clk_i`, and that each serial clock level lasts for several local clock cycles, so every edge is seen exactly once. They also assume that hold changes only while the serial clock is low and that the serial clock level is settled when chip select falls. The stimulus keeps all of this true by design. It changes the pins only on the falling edge of the local clock. It holds every serial clock phase for at least three local cycles. It toggles hold only in the low phase, and it sets the idle clock level two cycles before chip select falls.

// File: rtl/spif_pkg.sv
`timescale 1ns/1ps
package spif_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_JEDEC = 8'h9F;
  localparam logic [7:0] OP_ID    = 8'hAB;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] ID_SHORT = 8'h44;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_OUT, PH_SKIP} phase_e;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_STAT, SRC_JEDEC, SRC_ID} src_e;

  function automatic logic [7:0] jedec_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h62;
      2'd1:    return 8'h06;
      2'd2:    return 8'h12;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spif_front.sv
`timescale 1ns/1ps
module spif_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic rise_o,
  output logic fall_o,
  output logic held_o,
  output logic mode3_o
);
  logic sck_q, cs_q, hold_q, held_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      hold_q <= 1'b1;
      held_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sck_q  <= sck_i;
      cs_q   <= cs_ni;
      hold_q <= hold_ni;
      if (cs_q && !cs_ni) mode_q <= sck_i;
      if (cs_ni)                           held_q <= 1'b0;
      else if (hold_q && !hold_ni && !sck_i) held_q <= 1'b1;
      else if (!hold_q && hold_ni)         held_q <= 1'b0;
    end
  end

  assign rise_o  = !cs_ni && !held_q &&  sck_i && !sck_q;
  assign fall_o  = !cs_ni && !held_q && !sck_i &&  sck_q;
  assign held_o  = held_q;
  assign mode3_o = mode_q;

  // R1
  mode_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_q && !cs_ni) |=> (mode3_o == $past(sck_i)));
endmodule

// File: rtl/spif_regfile.sv
`timescale 1ns/1ps
module spif_regfile #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spif_seq.sv
`timescale 1ns/1ps
module spif_seq
  import spif_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              held_i,
  input  logic              si_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [MEM_AW-1:0] mem_raddr_o,
  output logic              so_o,
  output logic              so_oe_o
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  phase_e            phase_q;
  src_e              src_q;
  logic              fast_q, pd_q, pd_arm_q, so_q, oe_q;
  logic [2:0]        bit_cnt_q, tx_cnt_q;
  logic [1:0]        byte_cnt_q, id_idx_q;
  logic [6:0]        rx_sh_q, tx_sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rx_byte, cur_byte;
  logic              busy;

  assign rx_byte = {rx_sh_q, si_i};
  assign busy    = status_i[0];

  always_comb begin
    case (src_q)
      SRC_ARRAY: cur_byte = mem_rdata_i;
      SRC_STAT:  cur_byte = status_i;
      SRC_JEDEC: cur_byte = jedec_byte(id_idx_q);
      default:   cur_byte = ID_SHORT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      src_q      <= SRC_ARRAY;
      fast_q     <= 1'b0;
      pd_q       <= 1'b0;
      pd_arm_q   <= 1'b0;
      so_q       <= 1'b0;
      oe_q       <= 1'b0;
      bit_cnt_q  <= '0;
      tx_cnt_q   <= '0;
      byte_cnt_q <= '0;
      id_idx_q   <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      addr_q     <= '0;
    end else if (cs_ni) begin
      // deselect: commit a clean power-down request, clear serial state
      if (pd_arm_q) pd_q <= 1'b1;
      pd_arm_q   <= 1'b0;
      phase_q    <= PH_CMD;
      oe_q       <= 1'b0;
      bit_cnt_q  <= '0;
      tx_cnt_q   <= '0;
      byte_cnt_q <= '0;
      id_idx_q   <= '0;
    end else begin
      if (rise_i) begin
        rx_sh_q   <= rx_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 3'd1;
        pd_arm_q  <= 1'b0;
        if (bit_cnt_q == 3'd7) begin
          case (phase_q)
            PH_CMD: begin
              phase_q <= PH_SKIP;
              fast_q  <= 1'b0;
              if (pd_q) begin
                if (rx_byte == OP_ID) begin
                  pd_q    <= 1'b0;
                  phase_q <= PH_ADDR;
                  src_q   <= SRC_ID;
                end
              end else begin
                case (rx_byte)
                  OP_READ:  begin phase_q <= PH_ADDR; src_q <= SRC_ARRAY; end
                  OP_FREAD: begin phase_q <= PH_ADDR; src_q <= SRC_ARRAY; fast_q <= 1'b1; end
                  OP_STAT:  begin phase_q <= PH_OUT;  src_q <= SRC_STAT; end
                  OP_JEDEC: if (!busy) begin phase_q <= PH_OUT;  src_q <= SRC_JEDEC; end
                  OP_ID:    if (!busy) begin phase_q <= PH_ADDR; src_q <= SRC_ID; end
                  OP_SLEEP: if (!busy) pd_arm_q <= 1'b1;
                  default: ;
                endcase
              end
            end
            PH_ADDR: begin
              addr_q     <= {addr_q[ADDR_W-9:0], rx_byte};
              byte_cnt_q <= byte_cnt_q + 2'd1;
              if (byte_cnt_q == 2'd2) begin
                byte_cnt_q <= '0;
                phase_q    <= fast_q ? PH_DUMMY : PH_OUT;
              end
            end
            PH_DUMMY: phase_q <= PH_OUT;
            default: ;
          endcase
        end
      end
      if (fall_i && phase_q == PH_OUT) begin
        oe_q     <= 1'b1;
        tx_cnt_q <= tx_cnt_q + 3'd1;
        if (tx_cnt_q == 3'd0) begin
          so_q    <= cur_byte[7];
          tx_sh_q <= cur_byte[6:0];
          if (src_q == SRC_ARRAY) addr_q   <= addr_q + ADDR_ONE;
          if (src_q == SRC_JEDEC) id_idx_q <= id_idx_q + 2'd1;
        end else begin
          so_q    <= tx_sh_q[6];
          tx_sh_q <= {tx_sh_q[5:0], 1'b0};
        end
      end
    end
  end

  assign mem_raddr_o = addr_q[MEM_AW-1:0];
  assign so_o        = so_q;
  assign so_oe_o     = oe_q && !held_i;

  // R2
  so_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(so_q));
  // R2
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !so_oe_o);
  // R9
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_q && !cs_ni) |=> !pd_q);
  // R7
  id_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && rise_i && bit_cnt_q == 3'd7 && phase_q == PH_CMD && !pd_q &&
     busy && rx_byte == OP_JEDEC) |=> (phase_q == PH_SKIP));
endmodule

// File: rtl/spif_read_top.sv
`timescale 1ns/1ps
module spif_read_top #(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic [7:0]        status_i,
  input  logic              init_we_i,
  input  logic [MEM_AW-1:0] init_addr_i,
  input  logic [7:0]        init_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              mode3_o
);
  logic              rise, fall, held;
  logic [MEM_AW-1:0] raddr;
  logic [7:0]        rdata;

  spif_front u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .sck_i   (sck_i),
    .hold_ni (hold_ni),
    .rise_o  (rise),
    .fall_o  (fall),
    .held_o  (held),
    .mode3_o (mode3_o)
  );

  spif_regfile #(.AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (init_we_i),
    .waddr_i (init_addr_i),
    .wdata_i (init_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  spif_seq #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .held_i      (held),
    .si_i        (si_i),
    .status_i    (status_i),
    .mem_rdata_i (rdata),
    .mem_raddr_o (raddr),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o)
  );
endmodule

// File: tb/tb_spif_read_top.sv
`timescale 1ns/1ps
module tb_spif_read_top;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam logic [8:0] NONE  = 9'h000;
  localparam logic [8:0] MIXED = 9'h0AA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status = 8'h8C;
  logic we = 1'b0;
  logic [MEM_AW-1:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic so, so_oe, mode3;

  int checks = 0, bad = 0;
  logic cur_mode3 = 1'b0;
  logic [7:0] model [DEPTH];
  logic [8:0] exp_q[$];
  logic [8:0] act_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  spif_read_top #(.ADDR_W(18), .MEM_AW(MEM_AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .status_i(status), .init_we_i(we), .init_addr_i(waddr),
    .init_data_i(wdata), .so_o(so), .so_oe_o(so_oe), .mode3_o(mode3)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares produced bytes against the scoreboard
  always @(negedge clk) begin
    while (act_q.size() != 0) begin
      logic [8:0] e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic spi_bits(input logic [7:0] tx, input int nbits, input int hold_bit,
                          output logic [7:0] rx, output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int b = 7; b > 7 - nbits; b--) begin
      @(negedge clk);
      si = tx[b]; sck = 1'b0;
      repeat (4) @(negedge clk);
      if (b == hold_bit) begin
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(so_oe == 1'b0, "R10 hold floats SO", so_oe, 0);
        for (int k = 0; k < 2; k++) begin
          sck = 1'b1; si = ~si; repeat (3) @(negedge clk);
          sck = 1'b0; repeat (3) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
      end
      rx[b] = so; oe_all &= so_oe; oe_any |= so_oe;
      sck = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; logic oa, on;
    spi_bits(tx, 8, -1, rx, oa, on);
    chk(on == 1'b0, "R2 SO off while shifting in", on, 0);
  endtask

  task automatic expect_byte(input logic [8:0] e, input string tag, input int hold_bit);
    logic [7:0] rx; logic oa, on;
    exp_q.push_back(e); tag_q.push_back(tag);
    spi_bits(8'h00, 8, hold_bit, rx, oa, on);
    act_q.push_back(oa ? {1'b1, rx} : (on ? MIXED : NONE));
  endtask

  task automatic sel(input logic m3);
    @(negedge clk);
    cur_mode3 = m3; sck = m3;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk);
    sck = cur_mode3;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 37 + 11) ^ 8'h5A);
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      we = 1'b1; waddr = MEM_AW'(i); wdata = model[i];
      @(negedge clk);
    end
    we = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(so_oe == 1'b0, "R2 reset SO off", so_oe, 0);
    chk(mode3 == 1'b0, "R1 reset mode", mode3, 0);

    // R3 plain read, mode 0, R1
    sel(1'b0);
    chk(mode3 == 1'b0, "R1 mode 0 detect", mode3, 0);
    send(8'h03); send(8'h00); send(8'h00); send(8'h05);
    expect_byte({1'b1, model[5]}, "R3 read byte 0", -1);
    expect_byte({1'b1, model[6]}, "R3 read byte 1", -1);
    expect_byte({1'b1, model[7]}, "R3 read byte 2", -1);
    desel();
    chk(so_oe == 1'b0, "R2 SO off after deselect", so_oe, 0);

    // R4 fast read in mode 3, R1
    sel(1'b1);
    chk(mode3 == 1'b1, "R1 mode 3 detect", mode3, 1);
    send(8'h0B); send(8'h00); send(8'h00); send(8'h10); send(8'hA5);
    expect_byte({1'b1, model[16]}, "R4 fast read byte 0", -1);
    expect_byte({1'b1, model[17]}, "R4 fast read byte 1", -1);
    desel();

    // R5 wrap with upper address bits set
    sel(1'b0);
    send(8'h03); send(8'hFF); send(8'hFF); send(8'hFF);
    expect_byte({1'b1, model[DEPTH-1]}, "R5 top address", -1);
    expect_byte({1'b1, model[0]}, "R5 wrap to zero", -1);
    expect_byte({1'b1, model[1]}, "R5 after wrap", -1);
    desel();

    // R6 status, idle and busy
    sel(1'b0);
    send(8'h05);
    expect_byte({1'b1, 8'h8C}, "R6 status", -1);
    expect_byte({1'b1, 8'h8C}, "R6 status repeat", -1);
    desel();
    status = 8'h0F;
    sel(1'b1);
    send(8'h05);
    expect_byte({1'b1, 8'h0F}, "R6 status while busy", -1);
    expect_byte({1'b1, 8'h0F}, "R6 status busy repeat", -1);
    desel();

    // R7 id reads rejected while busy
    sel(1'b0);
    send(8'h9F);
    expect_byte(NONE, "R7 9F busy no output", -1);
    desel();
    sel(1'b0);
    send(8'hAB); send(8'h00); send(8'h00); send(8'h00);
    expect_byte(NONE, "R7 AB busy no output", -1);
    desel();

    // R9 power-down ignored while busy
    sel(1'b0);
    send(8'hB9);
    desel();
    status = 8'h8C;
    sel(1'b0);
    send(8'h05);
    expect_byte({1'b1, 8'h8C}, "R9 B9 ignored when busy", -1);
    desel();

    // R7 identification sequence
    sel(1'b0);
    send(8'h9F);
    expect_byte({1'b1, 8'h62}, "R7 id 0", -1);
    expect_byte({1'b1, 8'h06}, "R7 id 1", -1);
    expect_byte({1'b1, 8'h12}, "R7 id 2", -1);
    expect_byte({1'b1, 8'h00}, "R7 id 3", -1);
    expect_byte({1'b1, 8'h62}, "R7 id repeat", -1);
    desel();

    // R8 short id
    sel(1'b1);
    send(8'hAB); send(8'h12); send(8'h34); send(8'h56);
    expect_byte({1'b1, 8'h44}, "R8 short id", -1);
    expect_byte({1'b1, 8'h44}, "R8 short id repeat", -1);
    desel();

    // R9 power-down entry, blocking, exit
    sel(1'b0);
    send(8'hB9);
    desel();
    sel(1'b0);
    send(8'h05);
    expect_byte(NONE, "R9 status blocked in power-down", -1);
    desel();
    sel(1'b0);
    send(8'h03); send(8'h00); send(8'h00); send(8'h02);
    expect_byte(NONE, "R9 read blocked in power-down", -1);
    desel();
    sel(1'b0);
    send(8'hAB); send(8'h00); send(8'h00); send(8'h00);
    expect_byte({1'b1, 8'h44}, "R9 AB exits power-down", -1);
    desel();
    sel(1'b0);
    send(8'h05);
    expect_byte({1'b1, 8'h8C}, "R9 status after exit", -1);
    desel();

    // R10 hold in the middle of a data byte
    sel(1'b0);
    send(8'h03); send(8'h00); send(8'h00); send(8'h20);
    expect_byte({1'b1, model[32]}, "R10 byte across hold", 4);
    expect_byte({1'b1, model[33]}, "R10 byte after hold", -1);
    desel();

    // R11 partial transfer abandoned
    begin
      logic [7:0] rx; logic oa, on;
      sel(1'b0);
      send(8'h03); send(8'h00);
      spi_bits(8'hE0, 3, -1, rx, oa, on);
      desel();
    end
    sel(1'b0);
    send(8'h05);
    expect_byte({1'b1, 8'h8C}, "R11 fresh decode after abort", -1);
    desel();

    // R12 undefined opcode
    sel(1'b0);
    send(8'h5A);
    expect_byte(NONE, "R12 undefined opcode", -1);
    expect_byte(NONE, "R12 undefined opcode later", -1);
    desel();

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule